// File: doc/BRIEF.md
# Interrupt Source Controller with Replay

This block holds per-source delivery state for a contiguous window of interrupt sources and sits in front of a presentation controller. Each source carries a destination server number and an 8-bit priority. The value 0xFF means the source is masked. When a source fires, the block either sends an offer downstream or, if the source is masked, remembers the event so that it can be delivered when the source is later unmasked. The offer carries the global source number, the server and the priority.

The presentation controller can hand an offer back as rejected. The block marks that source, and on a replay request it walks every source in index order, one source per cycle. It clears each mark and offers the source again unless the source is masked. Configuration requests write or read a source's server and priority. Each request gets a registered response: a status of 0 for success or 0xFD (-3 in 8-bit two's complement) for bad arguments. End-of-interrupt notices are taken without any effect on source state.

Three streams use valid/ready: the fire input, the configuration request and the offer output. A transfer happens on a clock edge where both valid and ready are high. The sender must hold its payload stable while valid is high and ready is low. The offer is the only stage that can stall. Configuration has precedence over fire, and fire has precedence over the replay scan. The scan therefore advances only in cycles where the offer slot is free and neither input stream is presenting. Reject, replay request and end-of-interrupt are plain single-cycle pulses.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset no offer is valid, busy is low, and a read of any valid source reports server 0 and priority 0xFF.
- R2: Firing a source whose priority is 0xFF produces no offer and sets that source's pending-while-masked flag.
- R3: Firing a source whose priority is not 0xFF produces an offer in the following cycle with number BASE plus the local index, the stored server and the stored priority. No offer ever carries priority 0xFF or a number outside the window.
- R4: A valid configuration write stores server and priority. If the pending-while-masked flag was set and the new priority is not 0xFF, the flag is cleared and the source is offered in the following cycle with the new values. A second such write produces no offer.
- R5: A reject naming a source inside the window marks it. A replay offers every marked unmasked source in ascending index order and clears all marks, so an immediate second replay offers nothing. Rejects naming numbers outside the window are ignored.
- R6: A replay clears the mark of a masked source without offering it, and that clearing does not set its pending-while-masked flag.
- R7: A configuration request with a number outside [BASE, BASE+NUM_SRC) is refused with status 0xFD and zero data, and changes nothing. A write with server >= NUM_SRV, or with a 9-bit priority above 0xFF, is refused the same way.
- R8: Every accepted configuration request gets exactly one response in the next cycle. A successful read returns status 0 with the source's server and priority. A successful write returns status 0.
- R9: An end-of-interrupt pulse produces no offer and leaves all source state unchanged.
- R10: While offer_valid is high and offer_ready is low, the offer payload holds steady, and both trig_ready and cfg_ready are low.
- R11: busy rises in the cycle after a replay request and stays high for exactly NUM_SRC unstalled scan steps. A replay request that arrives during a scan adds exactly one further full pass.
- R12: If a reject names the source that the scan visits in that same cycle, the mark stays set. The visit still offers the source if it was marked, and the next replay offers it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Source fire request |
| trig_ready | output | 1 | Fire request accepted |
| trig_src | input | IDX_W | Local index of the firing source |
| cfg_valid | input | 1 | Configuration request valid |
| cfg_ready | output | 1 | Configuration request accepted |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_num | input | 16 | Global source number |
| cfg_srv | input | 8 | Server to store |
| cfg_prio | input | 9 | Priority to store; above 0xFF is refused |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_status | output | 8 | 0x00 success, 0xFD bad argument |
| resp_srv | output | 8 | Server read back (0 for writes and failures) |
| resp_prio | output | 8 | Priority read back (0 for writes and failures) |
| rej_valid | input | 1 | Reject pulse from the presentation side |
| rej_num | input | 16 | Global number of the rejected source |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_num | input | 16 | Global number of the completed source |
| resend_req | input | 1 | Replay request pulse |
| busy | output | 1 | Replay scan in progress |
| offer_valid | output | 1 | Offer to the presentation controller |
| offer_ready | input | 1 | Presentation controller takes the offer |
| offer_num | output | 16 | Global source number |
| offer_srv | output | 8 | Destination server |
| offer_prio | output | 8 | Priority |

## Verification
The replay scan and the reject input can act on the same source in the same cycle: the scan clears a mark while a reject sets it. The bench provokes this by pulsing a reject for source k exactly when the scan pointer reaches k, counting scan cycles from the rise of busy. It judges the outcome by checking that the visit still offered the source and that a following replay offers it once more. A second overlap, a replay request arriving mid-scan, is judged by the scan lasting exactly two passes.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int NUM_W  = 16;
  localparam int SRV_W  = 8;
  localparam int PRIO_W = 8;

  localparam logic [PRIO_W-1:0] PRIO_MASKED = 8'hFF;
  localparam logic [7:0]        ST_OK       = 8'h00;
  localparam logic [7:0]        ST_BADARG   = 8'hFD;

  typedef struct packed {
    logic [NUM_W-1:0]  num;
    logic [SRV_W-1:0]  srv;
    logic [PRIO_W-1:0] prio;
  } offer_t;
endpackage

// File: rtl/isc_src_table.sv
module isc_src_table
  import isc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SRV_W-1:0]  wr_srv,
  input  logic [PRIO_W-1:0] wr_prio,
  input  logic              mp_set,
  input  logic              mp_clr,
  input  logic [IDX_W-1:0]  mp_idx,
  input  logic              rej_set,
  input  logic [IDX_W-1:0]  rej_set_idx,
  input  logic              rej_clr,
  input  logic [IDX_W-1:0]  rej_clr_idx,
  output logic [SRV_W-1:0]  srv_q  [NUM_SRC],
  output logic [PRIO_W-1:0] prio_q [NUM_SRC],
  output logic              rej_q  [NUM_SRC],
  output logic              mp_q   [NUM_SRC]
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        srv_q[g]  <= '0;
        prio_q[g] <= PRIO_MASKED;
      end else if (wr_en && wr_idx == MY_IDX) begin
        srv_q[g]  <= wr_srv;
        prio_q[g] <= wr_prio;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                            mp_q[g] <= 1'b0;
      else if (mp_set && mp_idx == MY_IDX)   mp_q[g] <= 1'b1;
      else if (mp_clr && mp_idx == MY_IDX)   mp_q[g] <= 1'b0;
    end

    // a set in the same cycle as the scan's clear wins
    always_ff @(posedge clk) begin
      if (!rst_n)                                 rej_q[g] <= 1'b0;
      else if (rej_set && rej_set_idx == MY_IDX)  rej_q[g] <= 1'b1;
      else if (rej_clr && rej_clr_idx == MY_IDX)  rej_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/isc_resend_scan.sv
module isc_resend_scan #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resend_req,
  input  logic             step,
  output logic             busy,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

  logic again_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      ptr     <= '0;
      again_q <= 1'b0;
    end else if (!busy) begin
      if (resend_req) begin
        busy    <= 1'b1;
        ptr     <= '0;
        again_q <= 1'b0;
      end
    end else if (step && ptr == LAST) begin
      ptr     <= '0;
      again_q <= 1'b0;
      if (!(again_q || resend_req)) busy <= 1'b0;
    end else begin
      if (step)       ptr     <= ptr + 1'b1;
      if (resend_req) again_q <= 1'b1;
    end
  end
endmodule

// File: rtl/isc_offer_reg.sv
module isc_offer_reg
  import isc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  offer_t load_data,
  input  logic   ready,
  output logic   valid,
  output offer_t data,
  output logic   slot_free
);
  assign slot_free = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (slot_free) begin
      valid <= load;
      if (load) data <= load_data;
    end
  end
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import isc_pkg::*;
#(
  parameter int               NUM_SRC = 16,
  parameter int               NUM_SRV = 4,
  parameter logic [NUM_W-1:0] BASE    = 16'h0040,
  localparam int              IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic [IDX_W-1:0]  trig_src,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic              cfg_write,
  input  logic [NUM_W-1:0]  cfg_num,
  input  logic [SRV_W-1:0]  cfg_srv,
  input  logic [PRIO_W:0]   cfg_prio,
  output logic              resp_valid,
  output logic [7:0]        resp_status,
  output logic [SRV_W-1:0]  resp_srv,
  output logic [PRIO_W-1:0] resp_prio,
  input  logic              rej_valid,
  input  logic [NUM_W-1:0]  rej_num,
  input  logic              eoi_valid,
  input  logic [NUM_W-1:0]  eoi_num,
  input  logic              resend_req,
  output logic              busy,
  output logic              offer_valid,
  input  logic              offer_ready,
  output logic [NUM_W-1:0]  offer_num,
  output logic [SRV_W-1:0]  offer_srv,
  output logic [PRIO_W-1:0] offer_prio
);
  localparam logic [NUM_W-1:0] SPAN = NUM_W'(NUM_SRC);

  logic [SRV_W-1:0]  srv_q  [NUM_SRC];
  logic [PRIO_W-1:0] prio_q [NUM_SRC];
  logic              rej_q  [NUM_SRC];
  logic              mp_q   [NUM_SRC];

  logic             slot_free, scan_step, load;
  logic [IDX_W-1:0] scan_ptr;
  offer_t           load_data, out_data;

  // configuration decode
  logic [NUM_W-1:0] cfg_diff;
  logic [IDX_W-1:0] cfg_idx;
  logic             cfg_in, cfg_ok, cfg_fire, wr_en, unmask_offer;

  assign cfg_diff = cfg_num - BASE;
  assign cfg_in   = (cfg_num >= BASE) && (cfg_diff < SPAN);
  assign cfg_idx  = cfg_diff[IDX_W-1:0];
  assign cfg_ok   = cfg_in && (!cfg_write ||
                    ((int'(cfg_srv) < NUM_SRV) && !cfg_prio[PRIO_W]));
  assign cfg_ready    = slot_free;
  assign cfg_fire     = cfg_valid && cfg_ready;
  assign wr_en        = cfg_fire && cfg_write && cfg_ok;
  assign unmask_offer = wr_en && mp_q[cfg_idx] &&
                        (cfg_prio[PRIO_W-1:0] != PRIO_MASKED);

  // fire decode
  logic trig_fire, trig_ok, trig_masked;

  assign trig_ready  = slot_free && !cfg_valid;
  assign trig_fire   = trig_valid && trig_ready;
  assign trig_ok     = int'(trig_src) < NUM_SRC;
  assign trig_masked = prio_q[trig_src] == PRIO_MASKED;

  // reject decode
  logic [NUM_W-1:0] rej_diff;
  logic             rej_in;

  assign rej_diff = rej_num - BASE;
  assign rej_in   = rej_valid && (rej_num >= BASE) && (rej_diff < SPAN);

  // replay scan
  logic scan_visit, scan_offer;

  assign scan_step  = busy && slot_free && !cfg_valid && !trig_valid;
  assign scan_visit = scan_step && rej_q[scan_ptr];
  assign scan_offer = scan_visit && (prio_q[scan_ptr] != PRIO_MASKED);

  // offer source selection, one candidate at most by construction of the gates
  always_comb begin
    load      = 1'b0;
    load_data = '0;
    if (unmask_offer) begin
      load      = 1'b1;
      load_data = '{num: cfg_num, srv: cfg_srv, prio: cfg_prio[PRIO_W-1:0]};
    end else if (trig_fire && trig_ok && !trig_masked) begin
      load      = 1'b1;
      load_data = '{num: BASE + NUM_W'(trig_src), srv: srv_q[trig_src],
                    prio: prio_q[trig_src]};
    end else if (scan_offer) begin
      load      = 1'b1;
      load_data = '{num: BASE + NUM_W'(scan_ptr), srv: srv_q[scan_ptr],
                    prio: prio_q[scan_ptr]};
    end
  end

  isc_src_table #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_idx      (cfg_idx),
    .wr_srv      (cfg_srv),
    .wr_prio     (cfg_prio[PRIO_W-1:0]),
    .mp_set      (trig_fire && trig_ok && trig_masked),
    .mp_clr      (unmask_offer),
    .mp_idx      (unmask_offer ? cfg_idx : trig_src),
    .rej_set     (rej_in),
    .rej_set_idx (rej_diff[IDX_W-1:0]),
    .rej_clr     (scan_visit),
    .rej_clr_idx (scan_ptr),
    .srv_q       (srv_q),
    .prio_q      (prio_q),
    .rej_q       (rej_q),
    .mp_q        (mp_q)
  );

  isc_resend_scan #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .resend_req (resend_req),
    .step       (scan_step),
    .busy       (busy),
    .ptr        (scan_ptr)
  );

  isc_offer_reg u_offer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (load_data),
    .ready     (offer_ready),
    .valid     (offer_valid),
    .data      (out_data),
    .slot_free (slot_free)
  );

  assign offer_num  = out_data.num;
  assign offer_srv  = out_data.srv;
  assign offer_prio = out_data.prio;

  // configuration response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_status <= ST_OK;
      resp_srv    <= '0;
      resp_prio   <= '0;
    end else begin
      resp_valid <= cfg_fire;
      if (cfg_fire) begin
        resp_status <= cfg_ok ? ST_OK : ST_BADARG;
        resp_srv    <= (cfg_ok && !cfg_write) ? srv_q[cfg_idx]  : '0;
        resp_prio   <= (cfg_ok && !cfg_write) ? prio_q[cfg_idx] : '0;
      end
    end
  end
endmodule

// File: rtl/irq_source_ctrl_chk.sv
module irq_source_ctrl_chk
  import isc_pkg::*;
#(
  parameter int               NUM_SRC = 16,
  parameter logic [NUM_W-1:0] BASE    = 16'h0040
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_valid,
  input logic              trig_ready,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic              resp_valid,
  input logic [7:0]        resp_status,
  input logic [SRV_W-1:0]  resp_srv,
  input logic [PRIO_W-1:0] resp_prio,
  input logic              eoi_valid,
  input logic [NUM_W-1:0]  eoi_num,
  input logic              resend_req,
  input logic              busy,
  input logic              offer_valid,
  input logic              offer_ready,
  input logic [NUM_W-1:0]  offer_num,
  input logic [SRV_W-1:0]  offer_srv,
  input logic [PRIO_W-1:0] offer_prio
);
  assert_offer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid && !offer_ready |=> offer_valid && $stable(offer_num)
      && $stable(offer_srv) && $stable(offer_prio));

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid && !offer_ready |-> !trig_ready && !cfg_ready);

  assert_offer_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> offer_prio != PRIO_MASKED);

  assert_offer_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (offer_num >= BASE) && (offer_num - BASE < NUM_W'(NUM_SRC)));

  assert_status_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_status == ST_OK) || (resp_status == ST_BADARG));

  assert_refused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_status == ST_BADARG |-> resp_srv == '0 && resp_prio == '0);

  assert_resp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready |=> resp_valid);

  assert_resp_caused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && cfg_ready) |=> !resp_valid);

  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(resend_req));

  assert_eoi_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid && (eoi_num >= BASE) && !busy && !trig_valid && !cfg_valid
      && (!offer_valid || offer_ready) |=> !offer_valid);
endmodule

bind irq_source_ctrl irq_source_ctrl_chk #(.NUM_SRC(NUM_SRC), .BASE(BASE)) u_chk (.*);

// File: tb/test_irq_source_ctrl.sv
module test_irq_source_ctrl;
  import isc_pkg::*;

  localparam int               N      = 16;
  localparam int               NSRV   = 4;
  localparam logic [NUM_W-1:0] B      = 16'h0040;
  localparam int               IDX_W  = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_valid = 0, cfg_valid = 0, cfg_write = 0;
  logic rej_valid = 0, eoi_valid = 0, resend_req = 0, offer_ready = 1;
  logic [IDX_W-1:0]  trig_src = '0;
  logic [NUM_W-1:0]  cfg_num = '0, rej_num = '0, eoi_num = '0;
  logic [SRV_W-1:0]  cfg_srv = '0;
  logic [PRIO_W:0]   cfg_prio = '0;
  logic trig_ready, cfg_ready, resp_valid, busy, offer_valid;
  logic [7:0]        resp_status;
  logic [SRV_W-1:0]  resp_srv, offer_srv;
  logic [PRIO_W-1:0] resp_prio, offer_prio;
  logic [NUM_W-1:0]  offer_num;

  always #2 clk = ~clk;

  irq_source_ctrl #(.NUM_SRC(N), .NUM_SRV(NSRV), .BASE(B)) i_irq_source_ctrl (.*);

  int n_vec = 0, n_bad = 0;
  int m_srv [N];
  int m_prio[N];
  bit m_rej [N];
  bit m_mp  [N];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit in_win(int num);
    return num >= int'(B) && num < int'(B) + N;
  endfunction

  // expected offer word {num, srv, prio}
  function automatic logic [31:0] pack_off(int idx);
    return {16'(int'(B) + idx), 8'(m_srv[idx]), 8'(m_prio[idx])};
  endfunction

  task automatic check_offer(bit exp_v, logic [31:0] exp_w, string tag);
    chk(offer_valid == exp_v, tag, offer_valid, exp_v);
    if (exp_v && offer_valid)
      chk({offer_num, offer_srv, offer_prio} == exp_w, tag,
          {offer_num, offer_srv, offer_prio}, exp_w);
  endtask

  task automatic do_cfg(bit wr, int num, int srv, int prio, string tag);
    bit ok, off;
    int i;
    logic [31:0] w;
    ok  = in_win(num) && (!wr || (srv < NSRV && prio <= 255));
    i   = ok ? num - int'(B) : 0;
    off = ok && wr && m_mp[i] && prio != 255;
    w   = {16'(num), 8'(srv), 8'(prio)};
    cfg_valid = 1; cfg_write = wr; cfg_num = 16'(num);
    cfg_srv = 8'(srv); cfg_prio = 9'(prio);
    @(negedge clk);
    cfg_valid = 0;
    chk(resp_valid == 1'b1, {tag, " R8 resp"}, resp_valid, 1);
    chk(resp_status == (ok ? ST_OK : ST_BADARG), {tag, " R7 status"}, resp_status,
        ok ? ST_OK : ST_BADARG);
    if (ok && !wr)
      chk({resp_srv, resp_prio} == {8'(m_srv[i]), 8'(m_prio[i])}, {tag, " R8 data"},
          {resp_srv, resp_prio}, {8'(m_srv[i]), 8'(m_prio[i])});
    check_offer(off, w, {tag, " R4 offer"});
    if (ok && wr) begin
      m_srv[i] = srv; m_prio[i] = prio;
      if (off) m_mp[i] = 0;
    end
  endtask

  task automatic do_trig(int idx, string tag);
    bit masked;
    masked = m_prio[idx] == 255;
    trig_valid = 1; trig_src = IDX_W'(idx);
    @(negedge clk);
    trig_valid = 0;
    check_offer(!masked, pack_off(idx), tag);
    if (masked) m_mp[idx] = 1;
  endtask

  task automatic do_rej(int num);
    rej_valid = 1; rej_num = 16'(num);
    @(negedge clk);
    rej_valid = 0;
    if (in_win(num)) m_rej[num - int'(B)] = 1;
  endtask

  // replay; inj_k >= 0 pulses a reject of source inj_k as the scan reaches it,
  // mrg_k >= 0 pulses a second replay request mid-scan
  task automatic do_resend(int inj_k, int mrg_k, string tag);
    logic [31:0] expq[$];
    logic [31:0] gotq[$];
    int passes, it;
    passes = (mrg_k >= 0) ? 2 : 1;
    for (int p = 0; p < passes; p++)
      for (int i = 0; i < N; i++) begin
        if (m_rej[i]) begin
          m_rej[i] = 0;
          if (m_prio[i] != 255) expq.push_back(pack_off(i));
        end
        if (p == 0 && i == inj_k) m_rej[i] = 1;
      end
    resend_req = 1;
    @(negedge clk);
    resend_req = 0;
    chk(busy == 1'b1, {tag, " R11 busy rise"}, busy, 1);
    it = 0;
    while (busy && it < 3 * N) begin
      if (it == inj_k) begin rej_valid = 1; rej_num = 16'(int'(B) + inj_k); end
      if (it == mrg_k) resend_req = 1;
      @(negedge clk);
      rej_valid = 0; resend_req = 0;
      it++;
      if (offer_valid) gotq.push_back({offer_num, offer_srv, offer_prio});
    end
    chk(it == passes * N, {tag, " R11 scan length"}, it, passes * N);
    chk(gotq.size() == expq.size(), {tag, " R5 offer count"}, gotq.size(), expq.size());
    for (int k = 0; k < gotq.size() && k < expq.size(); k++)
      chk(gotq[k] == expq[k], {tag, " R5 offer order"}, gotq[k], expq[k]);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    int r, idx, num, srv, prio;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      m_srv[i] = 0; m_prio[i] = 255; m_rej[i] = 0; m_mp[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(offer_valid == 0, "R1 offer idle", offer_valid, 0);
    chk(busy == 0, "R1 busy idle", busy, 0);
    do_cfg(0, int'(B), 0, 0, "R1 read src0");
    do_cfg(0, int'(B) + N - 1, 0, 0, "R1 read last");

    // R2 masked fire, then R4 unmask delivery and single shot
    do_trig(2, "R2 masked fire");
    do_cfg(1, int'(B) + 2, 1, 5, "R4 unmask");
    do_cfg(1, int'(B) + 2, 3, 6, "R4 second write");
    do_trig(2, "R3 unmasked fire");

    // R7 refusals leave state alone
    do_cfg(1, int'(B) - 1, 0, 1, "R7 below window");
    do_cfg(1, int'(B) + N, 0, 1, "R7 above window");
    do_cfg(1, int'(B) + 2, NSRV, 1, "R7 bad server");
    do_cfg(1, int'(B) + 2, 0, 256, "R7 bad prio");
    do_cfg(0, int'(B) + N, 0, 0, "R7 read outside");
    do_cfg(0, int'(B) + 2, 0, 0, "R7 state kept");

    // R9 EOI has no effect
    eoi_valid = 1; eoi_num = B + 16'd2;
    @(negedge clk);
    eoi_valid = 0;
    chk(offer_valid == 0, "R9 eoi no offer", offer_valid, 0);
    do_cfg(0, int'(B) + 2, 0, 0, "R9 state kept");

    // R5 replay order and clearing; R6 masked mark is dropped
    do_cfg(1, int'(B) + 7, 2, 9, "R5 setup");
    do_rej(int'(B) + 7);
    do_rej(int'(B) + 2);
    do_rej(int'(B) + 5);
    do_rej(int'(B) + N + 3);
    do_resend(-1, -1, "R5 replay");
    do_resend(-1, -1, "R5 second replay");
    do_cfg(1, int'(B) + 5, 1, 3, "R6 unmask after replay");

    // R12 reject colliding with scan visit
    do_cfg(1, int'(B) + 3, 2, 4, "R12 setup");
    do_rej(int'(B) + 3);
    do_resend(3, -1, "R12 collide");
    do_resend(-1, -1, "R12 replay again");

    // R11 merged request during a scan
    do_rej(int'(B) + 7);
    do_resend(-1, 5, "R11 merge");

    // R10 back-pressure
    offer_ready = 0;
    do_trig(7, "R10 stall fire");
    repeat (3) begin
      @(negedge clk);
      check_offer(1, pack_off(7), "R10 hold");
      chk(!trig_ready && !cfg_ready, "R10 inputs stalled", {trig_ready, cfg_ready}, 0);
    end
    offer_ready = 1;
    @(negedge clk);
    chk(offer_valid == 0, "R10 drained", offer_valid, 1'b0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      r   = int'($urandom % 8);
      idx = int'($urandom % N);
      case (r)
        0, 1: begin
          prio = ($urandom % 3 == 0) ? 255 : int'($urandom % 255);
          do_cfg(1, int'(B) + idx, int'($urandom % NSRV), prio, "R4 rnd write");
        end
        2: begin
          num  = ($urandom % 2) ? int'(B) + N + int'($urandom % 8) : int'(B) + idx;
          srv  = int'($urandom % 8);
          prio = int'($urandom % 512);
          do_cfg(1, num, srv, prio, "R7 rnd write");
        end
        3: do_cfg(0, int'(B) + int'($urandom % (N + 4)) - 2, 0, 0, "R8 rnd read");
        4, 5: do_trig(idx, "R3 rnd fire");
        6: do_rej(int'(B) + idx);
        default: do_resend(-1, -1, "R5 rnd replay");
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule